// File: doc/BRIEF.md
# Byte-Lane Stream Width Adapter

This block joins two valid/ready streams that carry bytes in parallel lanes of the same width but have different numbers of lanes. When the output has more lanes, the adapter collects consecutive narrow beats into one wide beat. When the output has fewer lanes, it cuts each wide beat into a series of narrow beats. Each lane has a keep bit, and every beat carries an end-of-frame flag and a bad-frame flag. All three pass through with the data.

The adapter follows frame boundaries. When widening, a frame that ends before a wide beat is full is sent at once as a partial beat. When narrowing, lane groups at the end of a frame that hold no valid bytes are not sent. The bad-frame flag is taken from the final input beat of a frame and placed on the final output beat. The lane width and both lane counts are parameters. A lane ratio that is not an integer stops elaboration. With equal lane counts the block is a set of wires.

Top module: `lane_width_adapter`

## Requirements
- R1: A beat moves only on a cycle where valid and ready are both high. While the output is valid and not accepted, its data, keep, last and user hold their values.
- R2: When widening, narrow beats fill the wide beat starting at the lowest lane group. A wide beat is offered after a full set of OUT_LANES/IN_LANES narrow beats, with keep taken from the inputs.
- R3: When widening, an input beat with last high closes the wide beat early. Keep bits of the lane groups not filled are 0, and only lanes with keep 1 carry data.
- R4: When narrowing, a wide beat leaves as successive narrow beats, lowest lane group first. Each narrow beat carries that group's keep bits.
- R5: When narrowing, on a wide beat with last high, trailing lane groups whose keep bits are all 0 are not emitted. On a wide beat with last low, every group is emitted, even groups whose keep is 0.
- R6: Output last is high only on the final output beat made from an input beat with last high. Output user is high only there, and only if that input beat had user high. User on an input beat with last low is dropped.
- R7: While the wide side's output is valid and not ready, the input ready is low. When narrowing, input ready stays low until the final group of the held wide beat is being accepted.
- R8: If the output is always ready, the narrow side moves one beat every cycle. When widening, input ready never drops. When narrowing, the output beats of consecutive wide beats come out on consecutive cycles.
- R9: With equal lane counts, output data, keep, valid, last and user equal the inputs in the same cycle, and input ready equals output ready.
- R10: After a synchronous active-high reset, output valid is low and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | IN_LANES*LANE_W | Input lane data |
| s_keep | input | IN_LANES | Input lane-valid bits |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Adapter can take the input beat |
| s_last | input | 1 | Input end of frame |
| s_user | input | 1 | Input bad-frame flag, meaningful with s_last |
| m_data | output | OUT_LANES*LANE_W | Output lane data |
| m_keep | output | OUT_LANES | Output lane-valid bits |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream can take the output beat |
| m_last | output | 1 | Output end of frame |
| m_user | output | 1 | Output bad-frame flag, on the last beat only |

## Verification
The hardest case to reach is the moment when a held wide beat is giving up its final lane group while the next wide beat is waiting. At that point input ready depends on which group is final, and the final group depends on the end-of-frame flag and the keep pattern. To force that handover, the stimulus sends wide beats one after another, mixing full keep, partial keep with and without last, and a single-lane last beat. Each sequence runs twice: once with the output always ready, to time the handover, and once with a repeating ready pattern, so that stalls land on final and non-final groups and on partial wide beats.

// File: rtl/lane_adapt_pkg.sv
package lane_adapt_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_PACK  = 2'd1,
    MODE_SPLIT = 2'd2
  } adapt_mode_e;

  function automatic adapt_mode_e pick_mode(input int unsigned in_l, input int unsigned out_l);
    if (in_l == out_l) return MODE_PASS;
    if (in_l < out_l)  return MODE_PACK;
    return MODE_SPLIT;
  endfunction

  function automatic bit ratio_ok(input int unsigned a, input int unsigned b);
    if (a == 0 || b == 0) return 1'b0;
    if (a >= b) return (a % b) == 0;
    return (b % a) == 0;
  endfunction

endpackage

// File: rtl/lane_pack.sv
module lane_pack #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned NARROW = 1,
  parameter int unsigned WIDE   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NARROW*LANE_W-1:0] s_data,
  input  logic [NARROW-1:0]        s_keep,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic                     s_last,
  input  logic                     s_user,
  output logic [WIDE*LANE_W-1:0]   m_data,
  output logic [WIDE-1:0]          m_keep,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     m_last,
  output logic                     m_user
);
  localparam int unsigned RATIO = WIDE / NARROW;
  localparam int unsigned GW    = NARROW * LANE_W;
  localparam int unsigned IW    = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [IW-1:0]          grp;
  logic [WIDE*LANE_W-1:0] acc_data, nxt_data;
  logic [WIDE-1:0]        acc_keep, nxt_keep;
  logic                   take, close;

  // Merge the incoming narrow beat into the group currently being filled.
  always_comb begin
    nxt_data = acc_data;
    nxt_keep = acc_keep;
    nxt_data[int'(grp)*GW +: GW]     = s_data;
    nxt_keep[int'(grp)*NARROW +: NARROW] = s_keep;
  end

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;
  assign close   = take && (s_last || grp == IW'(RATIO - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      grp      <= '0;
      acc_data <= '0;
      acc_keep <= '0;
      m_data   <= '0;
      m_keep   <= '0;
      m_valid  <= 1'b0;
      m_last   <= 1'b0;
      m_user   <= 1'b0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (take) begin
        if (close) begin
          m_data   <= nxt_data;
          m_keep   <= nxt_keep;
          m_last   <= s_last;
          m_user   <= s_last && s_user;
          m_valid  <= 1'b1;
          grp      <= '0;
          acc_keep <= '0;
        end else begin
          acc_data <= nxt_data;
          acc_keep <= nxt_keep;
          grp      <= grp + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_split.sv
module lane_split #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned WIDE   = 4,
  parameter int unsigned NARROW = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WIDE*LANE_W-1:0]   s_data,
  input  logic [WIDE-1:0]          s_keep,
  input  logic                     s_valid,
  output logic                     s_ready,
  input  logic                     s_last,
  input  logic                     s_user,
  output logic [NARROW*LANE_W-1:0] m_data,
  output logic [NARROW-1:0]        m_keep,
  output logic                     m_valid,
  input  logic                     m_ready,
  output logic                     m_last,
  output logic                     m_user
);
  localparam int unsigned RATIO = WIDE / NARROW;
  localparam int unsigned GW    = NARROW * LANE_W;
  localparam int unsigned IW    = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [WIDE*LANE_W-1:0] h_data;
  logic [WIDE-1:0]        h_keep;
  logic                   h_valid, h_last, h_user;
  logic [IW-1:0]          grp;
  logic                   rest_empty, final_grp;

  // Groups above the current one carry no valid lane.
  assign rest_empty = (h_keep >> ((int'(grp) + 1) * NARROW)) == '0;
  assign final_grp  = (grp == IW'(RATIO - 1)) || (h_last && rest_empty);

  assign s_ready = !h_valid || (m_ready && final_grp);
  assign m_valid = h_valid;
  assign m_data  = h_data[int'(grp)*GW +: GW];
  assign m_keep  = h_keep[int'(grp)*NARROW +: NARROW];
  assign m_last  = h_last && final_grp;
  assign m_user  = h_user && h_last && final_grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_valid <= 1'b0;
      h_data  <= '0;
      h_keep  <= '0;
      h_last  <= 1'b0;
      h_user  <= 1'b0;
      grp     <= '0;
    end else if (s_valid && s_ready) begin
      h_valid <= 1'b1;
      h_data  <= s_data;
      h_keep  <= s_keep;
      h_last  <= s_last;
      h_user  <= s_user;
      grp     <= '0;
    end else if (h_valid && m_ready) begin
      if (final_grp) begin
        h_valid <= 1'b0;
        grp     <= '0;
      end else begin
        grp <= grp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_pass.sv
module lane_pass #(
  parameter int unsigned W     = 8,
  parameter int unsigned LANES = 1
) (
  input  logic [W-1:0]     s_data,
  input  logic [LANES-1:0] s_keep,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_last,
  input  logic             s_user,
  output logic [W-1:0]     m_data,
  output logic [LANES-1:0] m_keep,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_last,
  output logic             m_user
);
  assign m_data  = s_data;
  assign m_keep  = s_keep;
  assign m_valid = s_valid;
  assign m_last  = s_last;
  assign m_user  = s_user;
  assign s_ready = m_ready;
endmodule

// File: rtl/lane_width_adapter.sv
module lane_width_adapter
  import lane_adapt_pkg::*;
#(
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned IN_LANES  = 1,
  parameter int unsigned OUT_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IN_LANES*LANE_W-1:0]  s_data,
  input  logic [IN_LANES-1:0]         s_keep,
  input  logic                        s_valid,
  output logic                        s_ready,
  input  logic                        s_last,
  input  logic                        s_user,
  output logic [OUT_LANES*LANE_W-1:0] m_data,
  output logic [OUT_LANES-1:0]        m_keep,
  output logic                        m_valid,
  input  logic                        m_ready,
  output logic                        m_last,
  output logic                        m_user
);
  localparam adapt_mode_e MODE = pick_mode(IN_LANES, OUT_LANES);

  if (!ratio_ok(IN_LANES, OUT_LANES)) begin : g_bad_ratio
    $error("lane_width_adapter: lane counts must be integer multiples");
  end

  if (MODE == MODE_PASS) begin : g_pass
    lane_pass #(.W(IN_LANES*LANE_W), .LANES(IN_LANES)) pass_i (
      .s_data, .s_keep, .s_valid, .s_ready, .s_last, .s_user,
      .m_data, .m_keep, .m_valid, .m_ready, .m_last, .m_user
    );
  end else if (MODE == MODE_PACK) begin : g_pack
    lane_pack #(.LANE_W(LANE_W), .NARROW(IN_LANES), .WIDE(OUT_LANES)) pack_i (
      .clk, .rst,
      .s_data, .s_keep, .s_valid, .s_ready, .s_last, .s_user,
      .m_data, .m_keep, .m_valid, .m_ready, .m_last, .m_user
    );
  end else begin : g_split
    lane_split #(.LANE_W(LANE_W), .WIDE(IN_LANES), .NARROW(OUT_LANES)) split_i (
      .clk, .rst,
      .s_data, .s_keep, .s_valid, .s_ready, .s_last, .s_user,
      .m_data, .m_keep, .m_valid, .m_ready, .m_last, .m_user
    );
  end
endmodule

// File: rtl/lane_adapt_checker.sv
module lane_adapt_checker #(
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned IN_LANES  = 1,
  parameter int unsigned OUT_LANES = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        s_ready,
  input logic [OUT_LANES*LANE_W-1:0] m_data,
  input logic [OUT_LANES-1:0]        m_keep,
  input logic                        m_valid,
  input logic                        m_ready,
  input logic                        m_last,
  input logic                        m_user
);
  // R1: an offered beat that is not taken stays unchanged
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_keep)
                               && $stable(m_last) && $stable(m_user)));

  // R6: the bad-frame flag only rides on an end-of-frame beat
  assert_user_on_last_R6: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_user) |-> m_last);

  // R7: a stalled output pushes back on the input
  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  // R8: finishing an output frame beat frees the input in the same cycle
  assert_no_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_last) |-> s_ready);
endmodule

bind lane_width_adapter lane_adapt_checker #(
  .LANE_W(LANE_W), .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES)
) chk_i (
  .clk(clk), .rst(rst), .s_ready(s_ready),
  .m_data(m_data), .m_keep(m_keep), .m_valid(m_valid), .m_ready(m_ready),
  .m_last(m_last), .m_user(m_user)
);

// File: tb/lane_width_adapter_tb_top.sv
module lane_width_adapter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic mr = 1'b1;
  bit   mr_pat = 1'b0;

  // widening 1 -> 4 lanes
  logic [7:0]  u_sd = '0;  logic u_sk = 1'b0, u_sv = 1'b0, u_sl = 1'b0, u_su = 1'b0, u_sr;
  logic [31:0] u_md;       logic [3:0] u_mk; logic u_mv, u_ml, u_mu;
  // narrowing 4 -> 1 lanes
  logic [31:0] d_sd = '0;  logic [3:0] d_sk = '0; logic d_sv = 1'b0, d_sl = 1'b0, d_su = 1'b0, d_sr;
  logic [7:0]  d_md;       logic d_mk, d_mv, d_ml, d_mu;
  // equal 2 -> 2 lanes
  logic [15:0] p_sd = '0;  logic [1:0] p_sk = '0; logic p_sv = 1'b0, p_sl = 1'b0, p_su = 1'b0, p_sr, p_mr = 1'b0;
  logic [15:0] p_md;       logic [1:0] p_mk; logic p_mv, p_ml, p_mu;

  lane_width_adapter #(.LANE_W(8), .IN_LANES(1), .OUT_LANES(4)) dut_i (
    .clk, .rst, .s_data(u_sd), .s_keep(u_sk), .s_valid(u_sv), .s_ready(u_sr),
    .s_last(u_sl), .s_user(u_su), .m_data(u_md), .m_keep(u_mk), .m_valid(u_mv),
    .m_ready(mr), .m_last(u_ml), .m_user(u_mu));

  lane_width_adapter #(.LANE_W(8), .IN_LANES(4), .OUT_LANES(1)) dut_dn (
    .clk, .rst, .s_data(d_sd), .s_keep(d_sk), .s_valid(d_sv), .s_ready(d_sr),
    .s_last(d_sl), .s_user(d_su), .m_data(d_md), .m_keep(d_mk), .m_valid(d_mv),
    .m_ready(mr), .m_last(d_ml), .m_user(d_mu));

  lane_width_adapter #(.LANE_W(8), .IN_LANES(2), .OUT_LANES(2)) dut_pt (
    .clk, .rst, .s_data(p_sd), .s_keep(p_sk), .s_valid(p_sv), .s_ready(p_sr),
    .s_last(p_sl), .s_user(p_su), .m_data(p_md), .m_keep(p_mk), .m_valid(p_mv),
    .m_ready(p_mr), .m_last(p_ml), .m_user(p_mu));

  // stimulus {data, keep, last, user} and expected wide beats {data, keep, last, user}
  localparam logic [10:0] UP_VEC [11] = '{
    {8'h11,1'b1,1'b0,1'b0}, {8'h22,1'b1,1'b0,1'b0}, {8'h33,1'b1,1'b0,1'b0},
    {8'h44,1'b1,1'b0,1'b0}, {8'h55,1'b1,1'b0,1'b0}, {8'h66,1'b1,1'b1,1'b1},
    {8'h77,1'b1,1'b1,1'b0}, {8'h81,1'b1,1'b0,1'b1}, {8'h82,1'b1,1'b0,1'b0},
    {8'h83,1'b1,1'b0,1'b0}, {8'h84,1'b1,1'b1,1'b0}};
  localparam logic [37:0] UP_EXP [4] = '{
    {32'h44332211,4'hF,1'b0,1'b0}, {32'h00006655,4'h3,1'b1,1'b1},
    {32'h00000077,4'h1,1'b1,1'b0}, {32'h84838281,4'hF,1'b1,1'b0}};
  localparam logic [37:0] DN_VEC [4] = '{
    {32'hA4A3A2A1,4'hF,1'b0,1'b0}, {32'hB4B3B2B1,4'h3,1'b1,1'b1},
    {32'hC4C3C2C1,4'h3,1'b0,1'b0}, {32'hD4D3D2D1,4'h1,1'b1,1'b0}};
  localparam logic [10:0] DN_EXP [11] = '{
    {8'hA1,1'b1,1'b0,1'b0}, {8'hA2,1'b1,1'b0,1'b0}, {8'hA3,1'b1,1'b0,1'b0},
    {8'hA4,1'b1,1'b0,1'b0}, {8'hB1,1'b1,1'b0,1'b0}, {8'hB2,1'b1,1'b1,1'b1},
    {8'hC1,1'b1,1'b0,1'b0}, {8'hC2,1'b1,1'b0,1'b0}, {8'hC3,1'b0,1'b0,1'b0},
    {8'hC4,1'b0,1'b0,1'b0}, {8'hD1,1'b1,1'b1,1'b0}};

  logic [37:0] u_got [16];
  logic [10:0] d_got [16];
  int          d_cyc [16];
  int u_n = 0, d_n = 0, u_stall = 0;
  bit u_hold = 1'b0, d_hold = 1'b0;
  logic [37:0] u_prev;
  logic [10:0] d_prev;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern and cycle count, updated on the falling edge
  always @(negedge clk) begin
    cyc++;
    mr = mr_pat ? (cyc % 3 != 0) : 1'b1;
  end

  // output monitor, sampling well away from the rising edge
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (u_hold) chk(u_mv && {u_md,u_mk,u_ml,u_mu} == u_prev, "R1", {u_md,u_mk,u_ml,u_mu}, u_prev);
      if (d_hold) chk(d_mv && {d_md,d_mk,d_ml,d_mu} == d_prev, "R1", {d_md,d_mk,d_ml,d_mu}, d_prev);
      if (u_mv && !mr) chk(!u_sr, "R7 widen", u_sr, 0);
      if (d_mv && !mr && d_sr) chk(1'b0, "R7 narrow", d_sr, 0);
      u_hold = u_mv && !mr;
      d_hold = d_mv && !mr;
      u_prev = {u_md,u_mk,u_ml,u_mu};
      d_prev = {d_md,d_mk,d_ml,d_mu};
      if (u_mv && mr && u_n < 16) begin u_got[u_n] = {u_md,u_mk,u_ml,u_mu}; u_n++; end
      if (d_mv && mr && d_n < 16) begin d_got[d_n] = {d_md,d_mk,d_ml,d_mu}; d_cyc[d_n] = cyc; d_n++; end
    end
  end

  task automatic send_up(input logic [10:0] v);
    @(negedge clk);
    {u_sd, u_sk, u_sl, u_su} = v;
    u_sv = 1'b1;
    #1;
    while (!u_sr) begin u_stall++; @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_dn(input logic [37:0] v);
    @(negedge clk);
    {d_sd, d_sk, d_sl, d_su} = v;
    d_sv = 1'b1;
    #1;
    while (!d_sr) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic run_up();
    u_n = 0; u_stall = 0;
    for (int i = 0; i < 11; i++) send_up(UP_VEC[i]);
    @(negedge clk); u_sv = 1'b0;
    repeat (12) @(negedge clk);
    chk(u_n == 4, "R2 beat count", u_n, 4);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] mask = '0;
      for (int j = 0; j < 4; j++) if (UP_EXP[i][2+j]) mask[j*8 +: 8] = 8'hFF;
      // beat 0: full pack R2; beats 1,2: early close R3; beat 3: dropped mid-frame user R6
      chk((((u_got[i][37:6] ^ UP_EXP[i][37:6]) & mask) == '0) && u_got[i][5:0] == UP_EXP[i][5:0],
          (i == 0) ? "R2" : ((i == 3) ? "R6" : "R3"), u_got[i], UP_EXP[i]);
    end
  endtask

  task automatic run_dn();
    d_n = 0;
    for (int i = 0; i < 4; i++) send_dn(DN_VEC[i]);
    @(negedge clk); d_sv = 1'b0;
    repeat (20) @(negedge clk);
    chk(d_n == 11, "R5 beat count", d_n, 11);
    for (int i = 0; i < 11; i++) begin
      chk((!DN_EXP[i][2] || d_got[i][10:3] == DN_EXP[i][10:3]) && d_got[i][2:0] == DN_EXP[i][2:0],
          (i < 4) ? "R4" : ((i == 4 || (i > 5 && i < 10)) ? "R5" : "R6"), d_got[i], DN_EXP[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk(!u_mv, "R10 widen valid", u_mv, 0);
    chk(u_sr,  "R10 widen ready", u_sr, 1);
    chk(!d_mv, "R10 narrow valid", d_mv, 0);
    chk(d_sr,  "R10 narrow ready", d_sr, 1);

    // always-ready output: correctness and full narrow-side rate
    mr_pat = 1'b0;
    run_up();
    chk(u_stall == 0, "R8 widen stalls", u_stall, 0);
    run_dn();
    chk(d_cyc[5] - d_cyc[0] == 5, "R8 narrow back-to-back", d_cyc[5] - d_cyc[0], 5);
    chk(d_cyc[10] - d_cyc[6] == 4, "R8 narrow back-to-back", d_cyc[10] - d_cyc[6], 4);

    // repeating ready pattern: same results under stalls
    mr_pat = 1'b1;
    run_up();
    run_dn();
    mr_pat = 1'b0;

    // equal lane counts
    @(negedge clk);
    p_sd = 16'hBEEF; p_sk = 2'b01; p_sv = 1'b1; p_sl = 1'b1; p_su = 1'b1; p_mr = 1'b0;
    #1;
    chk({p_md,p_mk,p_mv,p_ml,p_mu} == {16'hBEEF,2'b01,3'b111}, "R9 pass", {p_md,p_mk,p_mv,p_ml,p_mu}, {16'hBEEF,2'b01,3'b111});
    chk(!p_sr, "R9 ready low", p_sr, 0);
    @(negedge clk); p_mr = 1'b1; #1;
    chk(p_sr, "R9 ready high", p_sr, 1);
    @(negedge clk); p_sv = 1'b0; #1;
    chk(!p_mv, "R9 valid low", p_mv, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule